// File: doc/BRIEF.md
# Configuration Register Unlock Detector

This block sits behind the bus-cycle decoder of a low-power pseudo-static memory. It watches the stream of finished bus cycles and recognises the command sequence that programs a small internal configuration register. Each bus cycle arrives as one event, a single-clock pulse on `ev_valid`. The event carries its direction, its 22-bit address and its 16-bit write data. It also carries two flags from the upstream decoder: one says whether chip select was cycled to frame the access, the other whether output enable was cycled during it. No storage array sits behind the command register. Only the configuration value is kept.

The command is four back-to-back cycles, all at the highest address. First come two reads. Then comes a write of the key value zero. Last comes a write of the setting itself. The setting carries the retention density in bits 1:0 and the page-length flag in bit 2. If the sequence completes, the block loads the register, raises the valid flag and pulses `set_ok`. A sequence that is spoiled after its two reads pulses `set_fail` and leaves the register as it was. A run of three or more reads of the top address also spoils the entry. The detector then ignores top-address reads until some other access is seen.

Top module: `cfgunl_detect`

## Requirements
- R1: While reset is held and immediately after it, `cfg_valid`, `set_ok` and `set_fail` are low.
- R2: Four consecutive events complete a setting: read of 3FFFFFh, read of 3FFFFFh, write of 0000h to 3FFFFFh, and write of a value in 0004h..0007h to 3FFFFFh. Every event in the sequence has chip select cycled, and both reads also have output enable cycled. On the clock edge that samples the last event, `cfg_density` takes data bits 1:0 (00 = 16 Mbit, 01 = 8 Mbit, 10 = 4 Mbit, 11 = 0 Mbit) and `cfg_page8` takes data bit 2. On that same edge `cfg_valid` goes high and `set_ok` pulses for one clock.
- R3: A third consecutive read of 3FFFFFh pulses `set_fail`. Later top-address reads do not start a new sequence, and a key write and setting write that follow leave the register unchanged.
- R4: After any event other than a read of 3FFFFFh, the next read of 3FFFFFh counts as the first read of a fresh sequence.
- R5: After the two reads, a write to 3FFFFFh of any value other than 0000h pulses `set_fail` and leaves the register unchanged.
- R6: A final write whose data lies outside 0004h..0007h, or has any of bits 15:3 set, pulses `set_fail` and leaves the register unchanged.
- R7: After the two reads, a write to an address other than 3FFFFFh in the key or the setting position pulses `set_fail` and leaves the register unchanged.
- R8: Out-of-order cycles never change the register. These include writes without the two reads, a write after a single read, and a non-top read after the two reads. The last of these pulses `set_fail`.
- R9: A read without chip select or output enable cycled does not count as a sequence read. A setting write without chip select cycled pulses `set_fail`. Neither changes the register.
- R10: `set_ok` and `set_fail` are never high together. The register value and `cfg_valid` change only on a `set_ok` edge, and `cfg_valid` never falls until reset.
- R11: Clocks with `ev_valid` low neither advance nor break a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One bus-cycle event this clock |
| ev_write | input | 1 | 1 = write cycle, 0 = read cycle |
| ev_addr | input | 22 | Word address of the cycle |
| ev_wdata | input | 16 | Write data (ignored for reads) |
| ev_cs_cycled | input | 1 | Chip select was toggled to frame this cycle |
| ev_oe_cycled | input | 1 | Output enable was toggled during this cycle |
| cfg_page8 | output | 1 | Page-length flag, 1 = eight-word page |
| cfg_density | output | 2 | Retention density code |
| cfg_valid | output | 1 | Register has been set since reset |
| set_ok | output | 1 | One-clock pulse: setting accepted |
| set_fail | output | 1 | One-clock pulse: started sequence was spoiled |

## Verification
Every result of this block is due on the first clock edge that samples the event causing it. This covers the `set_ok` or `set_fail` pulse and the new register value and valid flag. The driver applies each event on a falling edge. The monitor samples the event qualifier at the next rising edge and compares the outputs a quarter period later against the item queued for that event. Pulses are therefore checked in exactly the one cycle they may be high. On every clock without an event, the monitor also requires both pulses to be low, which catches pulses that arrive late or last too long.

// File: rtl/cfgunl_pkg.sv
package cfgunl_pkg;

   // Progress of the unlock walk.
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,   // nothing matched
      ST_ONE    = 3'd1,   // one top-address read seen
      ST_TWO    = 3'd2,   // two top-address reads seen
      ST_KEYED  = 3'd3,   // key write accepted, expecting setting
      ST_LOCKED = 3'd4    // run of top reads too long, wait for other access
   } unl_state_t;

   // Per-event classification handed from the decoder to the walker.
   typedef struct packed {
      logic top_rd_any;   // read of the top address, toggles not checked
      logic top_rd_good;  // read of the top address with both toggles
      logic key_good;     // framed write of the key value to the top address
      logic set_good;     // framed write of a legal setting to the top address
   } ev_class_t;

endpackage

// File: rtl/cfgunl_classify.sv
module cfgunl_classify
   import cfgunl_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16,
   parameter int DENS_W = 2,
   parameter logic [DATA_W-1:0] KEY_VALUE = '0
)(
   input  logic              ev_write,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_wdata,
   input  logic              ev_cs_cycled,
   input  logic              ev_oe_cycled,
   output ev_class_t         cls,
   output logic              new_page8,
   output logic [DENS_W-1:0] new_density
);
   localparam int                PAGE_BIT = DENS_W;
   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

   generate
      if (DATA_W < PAGE_BIT + 1) begin : g_bad_width
         $error("cfgunl_classify: DATA_W too small for density and page fields");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("cfgunl_classify: ADDR_W must be positive");
      end
   endgenerate

   logic is_top;
   logic upper_clear;

   assign is_top = (ev_addr == TOP_ADDR);

   // Bits above the page flag must be zero; absent when the word has none.
   generate
      if (DATA_W > PAGE_BIT + 1) begin : g_upper
         assign upper_clear = (ev_wdata[DATA_W-1:PAGE_BIT+1] == '0);
      end else begin : g_no_upper
         assign upper_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      cls.top_rd_any  = !ev_write && is_top;
      cls.top_rd_good = !ev_write && is_top && ev_cs_cycled && ev_oe_cycled;
      cls.key_good    = ev_write && is_top && ev_cs_cycled && (ev_wdata == KEY_VALUE);
      cls.set_good    = ev_write && is_top && ev_cs_cycled && upper_clear
                        && ev_wdata[PAGE_BIT];
   end

   assign new_page8   = ev_wdata[PAGE_BIT];
   assign new_density = ev_wdata[DENS_W-1:0];

endmodule

// File: rtl/cfgunl_fsm.sv
module cfgunl_fsm
   import cfgunl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_valid,
   input  ev_class_t  cls,
   output logic       do_commit,
   output logic       do_fail
);
   unl_state_t state_q, state_d;

   always_comb begin
      state_d   = state_q;
      do_commit = 1'b0;
      do_fail   = 1'b0;
      if (ev_valid) begin
         unique case (state_q)
            ST_IDLE: begin
               if (cls.top_rd_good) state_d = ST_ONE;
            end
            ST_ONE: begin
               state_d = cls.top_rd_good ? ST_TWO : ST_IDLE;
            end
            ST_TWO: begin
               if (cls.top_rd_any) begin
                  state_d = ST_LOCKED;
                  do_fail = 1'b1;
               end else if (cls.key_good) begin
                  state_d = ST_KEYED;
               end else begin
                  state_d = ST_IDLE;
                  do_fail = 1'b1;
               end
            end
            ST_KEYED: begin
               state_d = ST_IDLE;
               if (cls.set_good) do_commit = 1'b1;
               else              do_fail   = 1'b1;
            end
            ST_LOCKED: begin
               if (!cls.top_rd_any) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R3: a locked walker stays locked while top-address reads keep coming.
   a_r3_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCKED && ev_valid && cls.top_rd_any) |=> (state_q == ST_LOCKED));

   // R11: clocks without an event leave the walk untouched.
   a_r11_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(state_q));

   // R4: any event other than a top read ends the locked condition.
   a_r4_unlock_on_other: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCKED && ev_valid && !cls.top_rd_any) |=> (state_q == ST_IDLE));

   // R2: a commit is only possible from the keyed position.
   a_r2_commit_from_key: assert property (@(posedge clk) disable iff (!rst_n)
      do_commit |-> (state_q == ST_KEYED));

endmodule

// File: rtl/cfgunl_store.sv
module cfgunl_store #(
   parameter int DENS_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_commit,
   input  logic              do_fail,
   input  logic              new_page8,
   input  logic [DENS_W-1:0] new_density,
   output logic              cfg_page8,
   output logic [DENS_W-1:0] cfg_density,
   output logic              cfg_valid,
   output logic              set_ok,
   output logic              set_fail
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_page8   <= 1'b0;
         cfg_density <= '0;
         cfg_valid   <= 1'b0;
         set_ok      <= 1'b0;
         set_fail    <= 1'b0;
      end else begin
         set_ok   <= do_commit;
         set_fail <= do_fail;
         if (do_commit) begin
            cfg_page8   <= new_page8;
            cfg_density <= new_density;
            cfg_valid   <= 1'b1;
         end
      end
   end

   // R10: the two result pulses are exclusive.
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_ok && set_fail));

   // R10: register contents move only together with an accept pulse.
   a_r10_hold_without_ok: assert property (@(posedge clk) disable iff (!rst_n)
      !set_ok |-> $stable({cfg_page8, cfg_density, cfg_valid}));

   // R10: once set, the valid flag stays up.
   a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> cfg_valid);

   // R2: an accepted setting always leaves the register valid.
   a_r2_ok_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      set_ok |-> cfg_valid);

   // R1: nothing is flagged in the cycle after reset.
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!cfg_valid && !set_ok && !set_fail));

endmodule

// File: rtl/cfgunl_detect.sv
module cfgunl_detect
   import cfgunl_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16,
   parameter int DENS_W = 2,
   parameter logic [DATA_W-1:0] KEY_VALUE = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic              ev_write,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_wdata,
   input  logic              ev_cs_cycled,
   input  logic              ev_oe_cycled,
   output logic              cfg_page8,
   output logic [DENS_W-1:0] cfg_density,
   output logic              cfg_valid,
   output logic              set_ok,
   output logic              set_fail
);
   ev_class_t         cls;
   logic              nxt_page8;
   logic [DENS_W-1:0] nxt_density;
   logic              do_commit;
   logic              do_fail;

   cfgunl_classify #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DENS_W    (DENS_W),
      .KEY_VALUE (KEY_VALUE)
   ) u_classify (
      .ev_write     (ev_write),
      .ev_addr      (ev_addr),
      .ev_wdata     (ev_wdata),
      .ev_cs_cycled (ev_cs_cycled),
      .ev_oe_cycled (ev_oe_cycled),
      .cls          (cls),
      .new_page8    (nxt_page8),
      .new_density  (nxt_density)
   );

   cfgunl_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .cls       (cls),
      .do_commit (do_commit),
      .do_fail   (do_fail)
   );

   cfgunl_store #(
      .DENS_W (DENS_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .do_commit   (do_commit),
      .do_fail     (do_fail),
      .new_page8   (nxt_page8),
      .new_density (nxt_density),
      .cfg_page8   (cfg_page8),
      .cfg_density (cfg_density),
      .cfg_valid   (cfg_valid),
      .set_ok      (set_ok),
      .set_fail    (set_fail)
   );

   // R9: a spoiled setting never reports success at the same time.
   a_r9_no_ok_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      set_fail |-> !set_ok);

endmodule

// File: tb/cfgunl_detect_bench.sv
`timescale 1ns/1ps
module cfgunl_detect_bench;
   localparam logic [21:0] TOP = 22'h3FFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic        ev_write = 1'b0;
   logic [21:0] ev_addr = '0;
   logic [15:0] ev_wdata = '0;
   logic        ev_cs_cycled = 1'b0;
   logic        ev_oe_cycled = 1'b0;
   logic        cfg_page8;
   logic [1:0]  cfg_density;
   logic        cfg_valid;
   logic        set_ok;
   logic        set_fail;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Expected register contents, updated from R2 on every accepted setting.
   bit       cur_v = 1'b0;
   bit       cur_p = 1'b0;
   bit [1:0] cur_d = 2'b00;

   typedef struct {
      bit       ok;
      bit       fail;
      bit       valid;
      bit       page;
      bit [1:0] dens;
      string    tag;
   } exp_item_t;

   exp_item_t exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   cfgunl_detect u_cfgunl_detect (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_valid     (ev_valid),
      .ev_write     (ev_write),
      .ev_addr      (ev_addr),
      .ev_wdata     (ev_wdata),
      .ev_cs_cycled (ev_cs_cycled),
      .ev_oe_cycled (ev_oe_cycled),
      .cfg_page8    (cfg_page8),
      .cfg_density  (cfg_density),
      .cfg_valid    (cfg_valid),
      .set_ok       (set_ok),
      .set_fail     (set_fail)
   );

   // Driver: one event per call, applied on a falling edge.
   task automatic send(input bit wr, input logic [21:0] a, input logic [15:0] d,
                       input bit cs, input bit oe, input bit eok, input bit efail,
                       input string tag);
      exp_item_t it;
      if (eok) begin
         cur_v = 1'b1;
         cur_p = d[2];
         cur_d = d[1:0];
      end
      it.ok = eok; it.fail = efail; it.valid = cur_v;
      it.page = cur_p; it.dens = cur_d; it.tag = tag;
      exp_q.push_back(it);
      ev_valid = 1'b1; ev_write = wr; ev_addr = a; ev_wdata = d;
      ev_cs_cycled = cs; ev_oe_cycled = oe;
      @(negedge clk);
   endtask

   task automatic rd(input logic [21:0] a, input bit efail, input string tag);
      send(1'b0, a, 16'h0000, 1'b1, 1'b1, 1'b0, efail, tag);
   endtask

   task automatic wr(input logic [21:0] a, input logic [15:0] d, input bit eok,
                     input bit efail, input string tag);
      send(1'b1, a, d, 1'b1, 1'b0, eok, efail, tag);
   endtask

   task automatic gap(input int n);
      ev_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: results are due at the edge that samples the event.
   always @(posedge clk) begin
      bit fired;
      fired = ev_valid;
      #5;
      if (rst_n && fired) begin
         exp_item_t it;
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s: event with no expected item actual=event expected=none", "R11");
         end else begin
            it = exp_q.pop_front();
            if ({set_ok, set_fail, cfg_valid, cfg_page8, cfg_density} !==
                {it.ok, it.fail, it.valid, it.page, it.dens}) begin
               failures++;
               $display("FAIL %s: {ok,fail,valid,page,dens} actual=%b%b%b%b%02b expected=%b%b%b%b%02b",
                        it.tag, set_ok, set_fail, cfg_valid, cfg_page8, cfg_density,
                        it.ok, it.fail, it.valid, it.page, it.dens);
            end
         end
      end else if (rst_n && !fired) begin
         checks++;
         if (set_ok || set_fail) begin
            failures++;
            $display("FAIL R11: pulse on idle clock actual=%b%b expected=00", set_ok, set_fail);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL R11: watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 during reset
      if (cfg_valid || set_ok || set_fail) begin
         failures++;
         $display("FAIL R1: in reset actual=%b%b%b expected=000", cfg_valid, set_ok, set_fail);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 after reset
      if (cfg_valid || set_ok || set_fail) begin
         failures++;
         $display("FAIL R1: after reset actual=%b%b%b expected=000", cfg_valid, set_ok, set_fail);
      end

      // R2: density 8 Mbit, page flag set
      rd(TOP, 0, "R2"); rd(TOP, 0, "R2"); wr(TOP, 16'h0000, 0, 0, "R2");
      wr(TOP, 16'h0005, 1, 0, "R2");
      // R2: density 4 Mbit
      rd(TOP, 0, "R2"); rd(TOP, 0, "R2"); wr(TOP, 16'h0000, 0, 0, "R2");
      wr(TOP, 16'h0006, 1, 0, "R2");
      gap(2);

      // R3: third top read spoils, key and setting then ignored
      rd(TOP, 0, "R3"); rd(TOP, 0, "R3"); rd(TOP, 1, "R3");
      rd(TOP, 0, "R3"); wr(TOP, 16'h0000, 0, 0, "R3"); wr(TOP, 16'h0004, 0, 0, "R3");
      // R4: locked again, then a non-top read restarts the count
      rd(TOP, 0, "R4"); rd(TOP, 0, "R4"); rd(TOP, 1, "R4"); rd(TOP, 0, "R4");
      rd(22'h000010, 0, "R4");
      rd(TOP, 0, "R4"); rd(TOP, 0, "R4"); wr(TOP, 16'h0000, 0, 0, "R4");
      wr(TOP, 16'h0007, 1, 0, "R4");

      // R5: wrong key
      rd(TOP, 0, "R5"); rd(TOP, 0, "R5"); wr(TOP, 16'h0001, 0, 1, "R5");
      wr(TOP, 16'h0005, 0, 0, "R5");

      // R6: illegal settings
      rd(TOP, 0, "R6"); rd(TOP, 0, "R6"); wr(TOP, 16'h0000, 0, 0, "R6");
      wr(TOP, 16'h0003, 0, 1, "R6");
      rd(TOP, 0, "R6"); rd(TOP, 0, "R6"); wr(TOP, 16'h0000, 0, 0, "R6");
      wr(TOP, 16'h000C, 0, 1, "R6");
      rd(TOP, 0, "R6"); rd(TOP, 0, "R6"); wr(TOP, 16'h0000, 0, 0, "R6");
      wr(TOP, 16'h8005, 0, 1, "R6");

      // R7: wrong address in key and in setting position
      rd(TOP, 0, "R7"); rd(TOP, 0, "R7"); wr(22'h3FFFFE, 16'h0000, 0, 1, "R7");
      rd(TOP, 0, "R7"); rd(TOP, 0, "R7"); wr(TOP, 16'h0000, 0, 0, "R7");
      wr(22'h1FFFFF, 16'h0005, 0, 1, "R7");

      // R8: wrong order
      wr(TOP, 16'h0000, 0, 0, "R8"); wr(TOP, 16'h0005, 0, 0, "R8");
      rd(TOP, 0, "R8"); wr(TOP, 16'h0000, 0, 0, "R8"); wr(TOP, 16'h0005, 0, 0, "R8");
      rd(TOP, 0, "R8"); rd(TOP, 0, "R8"); rd(22'h000012, 1, "R8");
      wr(TOP, 16'h0000, 0, 0, "R8"); wr(TOP, 16'h0005, 0, 0, "R8");

      // R9: missing toggles
      send(1'b0, TOP, 16'h0000, 1'b1, 1'b0, 0, 0, "R9");
      rd(TOP, 0, "R9"); wr(TOP, 16'h0000, 0, 0, "R9"); wr(TOP, 16'h0005, 0, 0, "R9");
      send(1'b0, TOP, 16'h0000, 1'b0, 1'b1, 0, 0, "R9");
      rd(TOP, 0, "R9"); wr(TOP, 16'h0000, 0, 0, "R9"); wr(TOP, 16'h0005, 0, 0, "R9");
      rd(TOP, 0, "R9"); rd(TOP, 0, "R9"); wr(TOP, 16'h0000, 0, 0, "R9");
      send(1'b1, TOP, 16'h0005, 1'b0, 1'b0, 0, 1, "R9");

      // R11: gaps inside a good sequence; R2 with 16 Mbit
      rd(TOP, 0, "R11"); gap(3); rd(TOP, 0, "R11"); gap(2);
      wr(TOP, 16'h0000, 0, 0, "R11"); gap(4); wr(TOP, 16'h0004, 1, 0, "R11");

      // R10: unrelated traffic leaves the register alone
      wr(22'h000100, 16'h0007, 0, 0, "R10"); rd(22'h000100, 0, "R10");
      wr(TOP, 16'h0006, 0, 0, "R10");
      gap(3);

      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R11: unconsumed items actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule